// File: doc/BRIEF.md
# BCD Programmable Gate Generator

This block is one channel of a programmable pulse generator. The channel runs on a 10 MHz tick, so one clock is 100 ns. The pulse length is held as eight BCD digits, which covers up to 9.9999999 s. A start request opens the gate and clears a decimal counter. The counter then advances once per clock. The gate closes when the counter reaches the programmed length.

A one-clock begin marker is issued with the first gate cycle. A one-clock end marker is issued in the cycle right after the gate closes. Further start requests have no effect while the gate or its end marker is in progress.

The start input may come from any source, such as an external pulse, a push-button or a bus write, ORed together upstream. It is synchronised inside the block, and only its rising edge counts. The length word is sampled when the start is accepted. This lets the controlling logic change it at any time without disturbing a pulse that is already running.

Top module: `bcd_gate_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `gate_o`, `begin_mark_o`, `end_mark_o` and `busy_o` are all low.
- R2: When `start_i` is first sampled high by a rising clock edge while the block is idle, `gate_o` goes high just after the third rising edge that counts from that sampling edge (two synchroniser stages plus the control register).
- R3: The gate stays high for exactly N clock cycles. N is the value of `width_i` read as eight BCD digits, with digit i in bits [4i+3:4i] and a weight of 10^i clocks. The internal counter only ever holds valid BCD digits.
- R4: A length of zero gives a gate of one clock cycle.
- R5: `begin_mark_o` is high for exactly one cycle, the first cycle of the gate, and is low in every other gate cycle.
- R6: `end_mark_o` is high for exactly one cycle, the cycle right after the last gate cycle.
- R7: A start rising edge seen while the gate or the end marker is active produces no gate. A start held high produces only one gate.
- R8: `width_i` is captured when the start is accepted, so changing it during the gate has no effect on the gate's length.
- R9: `busy_o` is high in every gate cycle and in the end-marker cycle, and low in the cycle after the end marker.
- R10: A start whose rising edge reaches the control register in the first cycle after the end marker is accepted, so there is no dead time beyond the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz tick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, may be asynchronous; its rising edge is used |
| width_i | input | 32 | Gate length as eight BCD digits, least significant digit in bits [3:0] |
| gate_o | output | 1 | Gate output |
| begin_mark_o | output | 1 | One-clock pulse on the first gate cycle |
| end_mark_o | output | 1 | One-clock pulse right after the gate closes |
| busy_o | output | 1 | High from gate start through the end-marker cycle |

## Verification
The bench uses lengths whose count carries across one and two BCD digit boundaries. A binary counter, or one with a broken carry, would end those gates at the wrong cycle. It also applies the zero and one lengths: an off-by-one compare would stretch or drop the shortest gate. It fires starts mid-gate, holds a start high, and places a start edge exactly in the end-marker cycle; a design that retriggers would show an extra gate with nothing expected for it. A start placed one cycle later must be accepted, which catches over-long lockout. It also changes the length during a gate, which catches a design that compares against the live input.

// File: rtl/bcd_gate_pkg.sv
// Package: shared constants and the control state type for the BCD gate generator.
// Assumes one BCD digit is four bits wide.
package bcd_gate_pkg;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GATE = 2'd1,
        ST_TAIL = 2'd2
    } gate_state_e;
endpackage

// File: rtl/start_edge_det.sv
// Module: start_edge_det
// Brings an asynchronous start request into the clock domain through a
// flop chain and flags its rising edge for one cycle.
// Assumes STAGES >= 2 and that the request stays high for at least one clock.
module start_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the request through the synchroniser and keep the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A rising edge is a settled high that was low one cycle earlier.
    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bcd_cascade.sv
// Module: bcd_cascade
// Decimal up-counter made of DIGITS four-bit BCD digits in a ripple-carry
// cascade. A clear request overrides counting. The next value is exported
// so that a compare can act in the same cycle.
// Assumes the counter is cleared before use, so the digits stay in 0..9.
module bcd_cascade
    import bcd_gate_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      en_i,
    output logic [DIGITS*DIGIT_W-1:0] cnt_o,
    output logic [DIGITS*DIGIT_W-1:0] cnt_nxt_o
);
    localparam int CNT_W = DIGITS * DIGIT_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [DIGITS-1:0] carry;

    assign carry[0] = en_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [DIGIT_W-1:0] cur;
        assign cur = cnt_q[g*DIGIT_W +: DIGIT_W];
        // Wrap 9 to 0 when this digit is told to advance.
        assign cnt_nxt_o[g*DIGIT_W +: DIGIT_W] =
            carry[g] ? ((cur == DIGIT_MAX) ? '0 : cur + 1'b1) : cur;
        if (g < DIGITS - 1) begin : g_carry
            // Pass the carry on only when this digit is rolling over.
            assign carry[g+1] = carry[g] & (cur == DIGIT_MAX);
        end
    end

    // Hold the count, clearing it on reset or on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt_o;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/gate_ctrl.sv
// Module: gate_ctrl
// Control state machine of the gate generator. Starts are accepted only when
// idle. The length is captured at the start. The gate closes when the next
// count equals the length, and a one-cycle tail carries the end marker.
// Assumes the captured length holds valid BCD digits.
module gate_ctrl
    import bcd_gate_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_rise_i,
    input  logic [DIGITS*DIGIT_W-1:0] width_i,
    input  logic [DIGITS*DIGIT_W-1:0] cnt_nxt_i,
    output logic                      gate_o,
    output logic                      begin_mark_o,
    output logic                      end_mark_o,
    output logic                      busy_o,
    output logic                      cnt_en_o,
    output logic                      cnt_clr_o
);
    localparam int CNT_W = DIGITS * DIGIT_W;

    gate_state_e      state_q;
    logic [CNT_W-1:0] width_q;
    logic             gate_q;
    logic             bm_q;
    logic             em_q;
    logic             last_cycle;

    // The gate ends on this cycle if the count about to be reached is the length.
    // A zero length also ends it here, so the gate always lasts one cycle.
    assign last_cycle = (width_q == '0) || (cnt_nxt_i == width_q);

    // Step the state machine and register all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            width_q <= '0;
            gate_q  <= 1'b0;
            bm_q    <= 1'b0;
            em_q    <= 1'b0;
        end else begin
            bm_q <= 1'b0;
            em_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_rise_i) begin
                        state_q <= ST_GATE;
                        width_q <= width_i;
                        gate_q  <= 1'b1;
                        bm_q    <= 1'b1;
                    end
                end
                ST_GATE: begin
                    if (last_cycle) begin
                        state_q <= ST_TAIL;
                        gate_q  <= 1'b0;
                        em_q    <= 1'b1;
                    end
                end
                ST_TAIL: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                    gate_q  <= 1'b0;
                end
            endcase
        end
    end

    assign gate_o       = gate_q;
    assign begin_mark_o = bm_q;
    assign end_mark_o   = em_q;
    assign busy_o       = (state_q != ST_IDLE);
    assign cnt_en_o     = (state_q == ST_GATE);
    assign cnt_clr_o    = (state_q != ST_GATE);
endmodule

// File: rtl/bcd_gate_gen.sv
// Module: bcd_gate_gen (top)
// One channel of a BCD-programmed gate generator. Ties together the start
// synchroniser, the decimal counter and the control state machine.
// Assumes clk is the 100 ns tick and width_i holds valid BCD digits.
module bcd_gate_gen
    import bcd_gate_pkg::*;
#(
    parameter int DIGITS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [DIGITS*DIGIT_W-1:0] width_i,
    output logic                      gate_o,
    output logic                      begin_mark_o,
    output logic                      end_mark_o,
    output logic                      busy_o
);
    localparam int CNT_W = DIGITS * DIGIT_W;

    logic             start_rise;
    logic             cnt_en;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    start_edge_det #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (start_i),
        .rise_o  (start_rise)
    );

    bcd_cascade #(.DIGITS(DIGITS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cnt_clr),
        .en_i      (cnt_en),
        .cnt_o     (cnt_q),
        .cnt_nxt_o (cnt_nxt)
    );

    gate_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_rise_i (start_rise),
        .width_i      (width_i),
        .cnt_nxt_i    (cnt_nxt),
        .gate_o       (gate_o),
        .begin_mark_o (begin_mark_o),
        .end_mark_o   (end_mark_o),
        .busy_o       (busy_o),
        .cnt_en_o     (cnt_en),
        .cnt_clr_o    (cnt_clr)
    );
endmodule

// File: rtl/bcd_gate_gen_chk.sv
// Module: bcd_gate_gen_chk
// Property checker for bcd_gate_gen, attached with bind below. It watches the
// outputs and the internal count word.
// Assumes reset is held low across at least one clock edge at start-up.
module bcd_gate_gen_chk #(
    parameter int DIGITS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  gate,
    input logic                  begin_mark,
    input logic                  end_mark,
    input logic                  busy,
    input logic [DIGITS*4-1:0]   cnt
);
    AST_BEGIN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> begin_mark); // R5
    AST_BEGIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        begin_mark |=> !begin_mark); // R5
    AST_BEGIN_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        begin_mark |-> gate); // R5
    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> end_mark); // R6
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_mark |=> !end_mark); // R6
    AST_END_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        end_mark |-> !gate); // R6
    AST_NO_RETRIG_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        end_mark |=> !gate); // R7
    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate || end_mark) |-> busy); // R9
    AST_BUSY_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (gate || end_mark)); // R9
    AST_CNT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (cnt == '0)); // R3
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !end_mark) |-> (cnt == '0)); // R3

    for (genvar g = 0; g < DIGITS; g++) begin : g_bcd
        AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g*4 +: 4] <= 4'd9); // R3
    end
endmodule

bind bcd_gate_gen bcd_gate_gen_chk #(.DIGITS(DIGITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate       (gate_o),
    .begin_mark (begin_mark_o),
    .end_mark   (end_mark_o),
    .busy       (busy_o),
    .cnt        (cnt_q)
);

// File: tb/bcd_gate_gen_tb_top.sv
// Bench for bcd_gate_gen. A driver pushes expected gates into a queue, and a
// monitor pops and compares each gate the design produces.
module bcd_gate_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] width_i = '0;
    logic        gate_o, begin_mark_o, end_mark_o, busy_o;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        int    rise;
        int    len;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    bcd_gate_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .width_i      (width_i),
        .gate_o       (gate_o),
        .begin_mark_o (begin_mark_o),
        .end_mark_o   (end_mark_o),
        .busy_o       (busy_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: raise start for one cycle at the current falling edge, optionally push an expectation.
    task automatic pulse(input logic [31:0] w, input bit expect_gate, input int len, input string tag);
        width_i = w;
        start_i = 1'b1;
        if (expect_gate) exp_q.push_back('{rise: cyc + 3, len: len, tag: tag});
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_quiet();
        while (busy_o || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: measure each gate and its markers against the queue head.
    initial begin
        exp_t cur = '{rise: 0, len: 0, tag: "none"};
        int   run_len = 0;
        bit   g_prev = 1'b0;
        bit   after_em = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (gate_o && !g_prev) begin
                    if (exp_q.size() == 0) begin
                        check_eq("R7 unexpected gate", 1, 0);
                    end else begin
                        cur = exp_q.pop_front();
                        check_eq("R2 gate rise cycle", cyc, cur.rise);
                    end
                    check_eq("R5 begin marker on first cycle", int'(begin_mark_o), 1);
                    run_len = 1;
                end else if (gate_o) begin
                    run_len++;
                    check_eq("R5 begin marker low later", int'(begin_mark_o), 0);
                end
                if (gate_o) check_eq("R9 busy in gate", int'(busy_o), 1);
                if (!gate_o && g_prev) begin
                    check_eq(cur.tag, run_len, cur.len);
                    check_eq("R6 end marker after gate", int'(end_mark_o), 1);
                    check_eq("R9 busy in end marker", int'(busy_o), 1);
                    after_em = 1'b1;
                end else if (after_em) begin
                    check_eq("R6 end marker one cycle", int'(end_mark_o), 0);
                    check_eq("R9 busy released", int'(busy_o), 0);
                    after_em = 1'b0;
                end
                g_prev = gate_o;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 gate in reset", int'(gate_o), 0);
        check_eq("R1 busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R1 gate idle", int'(gate_o), 0);
        check_eq("R1 begin idle", int'(begin_mark_o), 0);
        check_eq("R1 end idle", int'(end_mark_o), 0);
        check_eq("R1 busy idle", int'(busy_o), 0);

        // R3: lengths within one digit and across digit carries.
        pulse(32'h0000_0007, 1'b1, 7, "R3 length 7");
        wait_quiet();
        pulse(32'h0000_0012, 1'b1, 12, "R3 length 12");
        wait_quiet();
        pulse(32'h0000_0100, 1'b1, 100, "R3 length 100");
        wait_quiet();

        // R4: zero length, plus length one.
        pulse(32'h0000_0000, 1'b1, 1, "R4 length 0");
        wait_quiet();
        pulse(32'h0000_0001, 1'b1, 1, "R4 length 1");
        wait_quiet();

        // R7: start held high gives one gate only.
        width_i = 32'h0000_0020;
        start_i = 1'b1;
        exp_q.push_back('{rise: cyc + 3, len: 20, tag: "R7 held start"});
        repeat (40) @(negedge clk);
        start_i = 1'b0;
        wait_quiet();

        // R7: second start mid-gate is ignored.
        pulse(32'h0000_0015, 1'b1, 15, "R7 mid-gate retrigger");
        repeat (5) @(negedge clk);
        pulse(32'h0000_0015, 1'b0, 0, "");
        wait_quiet();

        // R7: start edge landing in the end-marker cycle is ignored.
        pulse(32'h0000_0004, 1'b1, 4, "R7 first of tail pair");
        repeat (4) @(negedge clk);
        pulse(32'h0000_0004, 1'b0, 0, "");
        wait_quiet();

        // R10: start edge landing one cycle after the end marker is accepted.
        pulse(32'h0000_0004, 1'b1, 4, "R10 first of back pair");
        repeat (5) @(negedge clk);
        pulse(32'h0000_0003, 1'b1, 3, "R10 back-to-back gate");
        wait_quiet();

        // R8: length change during the gate has no effect.
        pulse(32'h0000_0009, 1'b1, 9, "R8 length captured");
        repeat (5) @(negedge clk);
        width_i = 32'h0000_0003;
        wait_quiet();

        check_eq("R7 no pending expectations", exp_q.size(), 0);
        check_eq("R1 idle at end", int'(gate_o), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule